// File: doc/BRIEF.md
# LRU Stack-Distance Associativity Profiler

The profiler takes a stream of memory addresses and, in a single pass, gathers enough information to give the miss count of a cache at every associativity from one way up to `WAYS`. The number of sets and the line size are fixed by parameters.

Each set holds a recency-ordered stack of up to `WAYS` line tags. For every reference the unit finds the depth at which the tag sits in its set's stack. Depth 0 is the most recently used entry. It then bumps the counter for that depth, or a separate "beyond" counter when the tag is absent. A reference at depth d hits in every cache with more than d ways, so the miss count for k ways is the total reference count minus the sum of the counters for depths below k.

As a side stream, the unit forwards every address that misses in the direct-mapped configuration. This forms a reduced trace that carries every state change of that configuration. The side stream has a valid/ready handshake, and backpressure on it stalls the input stream.

Top module: `lru_depth_profiler`

## Requirements
- R1: After reset all counters read zero, every set stack is empty, `red_valid_o` is low and `req_ready_o` is high.
- R2: `ref_cnt_o` increments by exactly one in the cycle after each accepted reference (`req_valid_i && req_ready_o` at a clock edge) and is otherwise unchanged.
- R3: An accepted reference whose tag sits at stack depth d (0 = most recent) increments the counter at bits `[d*CNT_W +: CNT_W]` of `hit_cnt_o`. A tag that is absent increments the counter at index `WAYS`. No other counter changes.
- R4: On each accepted reference the referenced tag moves to depth 0 and the entries above its old depth shift down by one. On an absent tag every entry shifts down, and the entry at depth `WAYS-1` is discarded.
- R5: The set index is `req_addr_i[OFFSET_W +: SET_W]` and the tag is the remaining upper bits. The offset bits do not affect matching, and each set's stack is independent of the others.
- R6: An accepted reference is forwarded on `red_addr_o`, with the full address, exactly when it is not at depth 0 (a direct-mapped miss). `red_valid_o` rises in the cycle after acceptance. A depth-0 reference forwards nothing.
- R7: While `red_valid_o` is high and `red_ready_i` is low, `req_ready_o` is low and `red_addr_o` holds its value.
- R8: For every k in 1..`WAYS`, `ref_cnt_o` minus the sum of the depth counters below k equals the k-way LRU miss count. A cyclic trace of `WAYS+1` distinct tags in one set misses on every reference at k = `WAYS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Input address valid |
| req_ready_o | output | 1 | Input address accepted when high |
| req_addr_i | input | ADDR_W | Byte address of the reference |
| red_valid_o | output | 1 | Reduced-trace address valid |
| red_ready_i | input | 1 | Reduced-trace consumer ready |
| red_addr_o | output | ADDR_W | Address that missed in the direct-mapped configuration |
| hit_cnt_o | output | (WAYS+1)*CNT_W | Depth counters 0..WAYS-1, then the beyond-stack counter at index WAYS |
| ref_cnt_o | output | CNT_W | Total accepted references |

## Verification
All results take effect at the clock edge that accepts a reference. The counters, the stack state and `red_valid_o` change at that edge, with no further pipeline stage. `req_ready_o` is combinational from `red_valid_o` and `red_ready_i`.

The bench drives inputs and samples outputs on the falling edge. After settling the inputs it decides from the port values which handshakes will fire at the next rising edge, advances a queue-based LRU model for those transfers, and compares every counter and the reduced-trace head one half-cycle after that edge. The stall rule is checked within the same half-cycle, right after the ready input is driven.

// File: rtl/lru_prof_pkg.sv
package lru_prof_pkg;
  localparam int unsigned DEF_ADDR_W   = 12;
  localparam int unsigned DEF_OFFSET_W = 2;
  localparam int unsigned DEF_SET_W    = 2;
  localparam int unsigned DEF_WAYS     = 4;
  localparam int unsigned DEF_CNT_W    = 32;

  function automatic int unsigned depth_bits(input int unsigned ways);
    return $clog2(ways + 1);
  endfunction
endpackage

// File: rtl/lru_set_stack.sv
module lru_set_stack
  import lru_prof_pkg::*;
#(
  parameter int unsigned SET_W   = DEF_SET_W,
  parameter int unsigned TAG_W   = 8,
  parameter int unsigned WAYS    = DEF_WAYS,
  localparam int unsigned SETS    = 1 << SET_W,
  localparam int unsigned DEPTH_W = depth_bits(WAYS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_i,
  input  logic [SET_W-1:0]   set_i,
  input  logic [TAG_W-1:0]   tag_i,
  output logic [DEPTH_W-1:0] depth_o
);
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = vld_q[set_i][w] && (tag_q[set_i][w] == tag_i);
  end

  always_comb begin
    depth_o = DEPTH_W'(WAYS);
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) depth_o = DEPTH_W'(w);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) tag_q[s][w] <= '0;
      end
    end else if (upd_i) begin
      // shift entries above the hit depth down by one; a miss shifts all
      for (int w = 1; w < WAYS; w++) begin
        if (DEPTH_W'(w) <= depth_o) begin
          tag_q[set_i][w] <= tag_q[set_i][w-1];
          vld_q[set_i][w] <= vld_q[set_i][w-1];
        end
      end
      tag_q[set_i][0] <= tag_i;
      vld_q[set_i][0] <= 1'b1;
    end
  end

  // R4: a tag lives in at most one stack slot
  a_r4_unique_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
  // R4: valid entries fill the stack from the top with no gaps
  a_r4_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((vld_q[set_i] & (vld_q[set_i] + 1'b1)) == '0));
endmodule

// File: rtl/depth_counters.sv
module depth_counters
  import lru_prof_pkg::*;
#(
  parameter int unsigned WAYS  = DEF_WAYS,
  parameter int unsigned CNT_W = DEF_CNT_W,
  localparam int unsigned DEPTH_W = depth_bits(WAYS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        inc_i,
  input  logic [DEPTH_W-1:0]          depth_i,
  output logic [(WAYS+1)*CNT_W-1:0]   cnt_o,
  output logic [CNT_W-1:0]            ref_o
);
  for (genvar d = 0; d <= WAYS; d++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_o[d*CNT_W +: CNT_W] <= '0;
      else if (inc_i && depth_i == DEPTH_W'(d))
        cnt_o[d*CNT_W +: CNT_W] <= cnt_o[d*CNT_W +: CNT_W] + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_o <= '0;
    else if (inc_i) ref_o <= ref_o + 1'b1;
  end

  logic [CNT_W-1:0] cnt_sum;
  always_comb begin
    cnt_sum = '0;
    for (int d = 0; d <= WAYS; d++) cnt_sum = cnt_sum + cnt_o[d*CNT_W +: CNT_W];
  end

  a_r2_ref_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> ref_o == $past(ref_o) + 1'b1);
  a_r2_ref_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(ref_o));
  // R3: every reference lands in exactly one depth bin
  a_r3_bins_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_sum == ref_o);
endmodule

// File: rtl/miss_filter.sv
module miss_filter
  import lru_prof_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic              can_accept_o
);
  assign can_accept_o = !out_valid_o || out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_addr_o  <= '0;
    end else if (push_i) begin
      out_valid_o <= 1'b1;
      out_addr_o  <= addr_i;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_addr_o));
  a_r7_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !can_accept_o);
  a_r6_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> out_valid_o);
endmodule

// File: rtl/lru_depth_profiler.sv
module lru_depth_profiler
  import lru_prof_pkg::*;
#(
  parameter int unsigned ADDR_W   = DEF_ADDR_W,
  parameter int unsigned OFFSET_W = DEF_OFFSET_W,
  parameter int unsigned SET_W    = DEF_SET_W,
  parameter int unsigned WAYS     = DEF_WAYS,
  parameter int unsigned CNT_W    = DEF_CNT_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic [ADDR_W-1:0]         req_addr_i,
  output logic                      red_valid_o,
  input  logic                      red_ready_i,
  output logic [ADDR_W-1:0]         red_addr_o,
  output logic [(WAYS+1)*CNT_W-1:0] hit_cnt_o,
  output logic [CNT_W-1:0]          ref_cnt_o
);
  localparam int unsigned TAG_W   = ADDR_W - SET_W - OFFSET_W;
  localparam int unsigned DEPTH_W = depth_bits(WAYS);

  logic               fire, dm_miss;
  logic [SET_W-1:0]   set_idx;
  logic [TAG_W-1:0]   tag;
  logic [DEPTH_W-1:0] depth;

  assign set_idx = req_addr_i[OFFSET_W +: SET_W];
  assign tag     = req_addr_i[ADDR_W-1 -: TAG_W];
  assign fire    = req_valid_i && req_ready_o;
  // direct-mapped resident line == top of the LRU stack
  assign dm_miss = depth != '0;

  lru_set_stack #(.SET_W(SET_W), .TAG_W(TAG_W), .WAYS(WAYS)) u_stack (
    .clk_i, .rst_ni, .upd_i(fire), .set_i(set_idx), .tag_i(tag), .depth_o(depth)
  );

  depth_counters #(.WAYS(WAYS), .CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .inc_i(fire), .depth_i(depth), .cnt_o(hit_cnt_o), .ref_o(ref_cnt_o)
  );

  miss_filter #(.ADDR_W(ADDR_W)) u_filt (
    .clk_i, .rst_ni, .push_i(fire && dm_miss), .addr_i(req_addr_i),
    .out_valid_o(red_valid_o), .out_ready_i(red_ready_i), .out_addr_o(red_addr_o),
    .can_accept_o(req_ready_o)
  );

  // R6: a depth-0 reference leaves the reduced stream empty
  a_r6_hit_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !dm_miss |=> !red_valid_o);
  // R6: a forwarded address is the one accepted
  a_r6_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && dm_miss |=> red_addr_o == $past(req_addr_i));
endmodule

// File: tb/sim_lru_depth_profiler.sv
module sim_lru_depth_profiler;
  localparam int ADDR_W = 12, OFFSET_W = 2, SET_W = 2, WAYS = 4, CNT_W = 32;
  localparam int NSETS = 1 << SET_W;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, red_ready = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_ready, red_valid;
  logic [ADDR_W-1:0] red_addr;
  logic [(WAYS+1)*CNT_W-1:0] hit_cnt;
  logic [CNT_W-1:0] ref_cnt;

  always #2 clk = ~clk;

  lru_depth_profiler #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .SET_W(SET_W),
                       .WAYS(WAYS), .CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .red_valid_o(red_valid), .red_ready_i(red_ready),
    .red_addr_o(red_addr), .hit_cnt_o(hit_cnt), .ref_cnt_o(ref_cnt)
  );

  int checks = 0, failures = 0;
  int m_ref = 0;
  int m_hit [WAYS+1];
  int stk [NSETS][$];
  int exp_red [$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cnt_at(input int d);
    return int'(hit_cnt[d*CNT_W +: CNT_W]);
  endfunction

  function automatic void model_access(input int a);
    int s, t, d;
    s = (a >> OFFSET_W) & (NSETS - 1);
    t = a >> (OFFSET_W + SET_W);
    d = WAYS;
    foreach (stk[s][i]) if (stk[s][i] == t && d == WAYS) d = i;
    if (d < WAYS) stk[s].delete(d);
    else if (stk[s].size() == WAYS) void'(stk[s].pop_back());
    stk[s].push_front(t);
    m_hit[d]++;
    m_ref++;
    if (d != 0) exp_red.push_back(a);
  endfunction

  task automatic compare();
    chk(int'(ref_cnt) == m_ref, "R2 ref_cnt", ref_cnt, m_ref);
    for (int d = 0; d <= WAYS; d++)
      chk(cnt_at(d) == m_hit[d], $sformatf("R3 R4 R5 depth%0d", d), cnt_at(d), m_hit[d]);
    chk(red_valid == (exp_red.size() != 0), "R6 red_valid", red_valid, exp_red.size() != 0);
    if (red_valid && exp_red.size() != 0)
      chk(int'(red_addr) == exp_red[0], "R6 red_addr", red_addr, exp_red[0]);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input bit v, input int a, input bit rdy);
    bit fin, fout;
    req_valid = v;
    req_addr  = ADDR_W'(a);
    red_ready = rdy;
    #1;
    if (red_valid && !rdy) chk(req_ready == 1'b0, "R7 stall", req_ready, 0);
    fin  = v && req_ready;
    fout = red_valid && rdy;
    if (fout) void'(exp_red.pop_front());
    if (fin) model_access(a);
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int sum_lo;
    foreach (m_hit[i]) m_hit[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(ref_cnt == 0, "R1 ref_cnt", ref_cnt, 0);
    for (int d = 0; d <= WAYS; d++) chk(cnt_at(d) == 0, "R1 counter", cnt_at(d), 0);
    chk(red_valid == 0, "R1 red_valid", red_valid, 0);
    chk(req_ready == 1, "R1 req_ready", req_ready, 1);

    // R8 cyclic WAYS+1 tags in set 1
    for (int r = 0; r < 4; r++)
      for (int t = 0; t <= WAYS; t++)
        step(1, (t << (OFFSET_W + SET_W)) | (1 << OFFSET_W) | t % 4, 1);
    sum_lo = 0;
    for (int d = 0; d < WAYS; d++) sum_lo += cnt_at(d);
    chk(int'(ref_cnt) - sum_lo == 4 * (WAYS + 1), "R8 cyclic k=WAYS misses",
        int'(ref_cnt) - sum_lo, 4 * (WAYS + 1));

    // R5 same line, different offset: depth 0, nothing forwarded
    step(1, (9 << (OFFSET_W + SET_W)) | (2 << OFFSET_W) | 1, 1);
    step(1, (9 << (OFFSET_W + SET_W)) | (2 << OFFSET_W) | 3, 1);
    chk(red_valid == 0, "R5 R6 offset ignored", red_valid, 0);

    // randomized trace with backpressure
    for (int n = 0; n < 4000; n++)
      step($urandom_range(0, 3) != 0,
           ($urandom_range(0, 7) << (OFFSET_W + SET_W)) | $urandom_range(0, 255) % (1 << (OFFSET_W + SET_W)),
           $urandom_range(0, 9) < 7);
    for (int n = 0; n < 4; n++) step(0, 0, 1);

    // R8 derived miss counts per k against model
    for (int k = 1; k <= WAYS; k++) begin
      int dut_sum = 0, mdl_sum = 0;
      for (int d = 0; d < k; d++) begin
        dut_sum += cnt_at(d);
        mdl_sum += m_hit[d];
      end
      chk(int'(ref_cnt) - dut_sum == m_ref - mdl_sum, $sformatf("R8 misses k=%0d", k),
          int'(ref_cnt) - dut_sum, m_ref - mdl_sum);
    end
    summary();
    $finish;
  end
endmodule